// File: doc/BRIEF.md
# VLIW Integer ALU Unit

This block is the integer execution slice of one issue slot in a clustered VLIW datapath. Each cycle it takes a 7-bit operation code, two 32-bit operands and a single-bit branch-register value. Operand `src2_i` may come from a register or from an immediate that has already been assembled upstream. The unit computes a general 32-bit result, a 1-bit branch-register result and a carry-out. One register stage holds all outputs, so a result appears one clock after its operands are presented.

The unit covers several groups of operations:
- plain, reversed and shift-fused addition;
- bitwise logic, with or without an inverted first operand;
- shifts;
- signed and unsigned min/max;
- byte and halfword extension;
- ten compares and four logical booleans;
- moving a general value into a branch register;
- conditional select;
- carry-chained addition.

Any code outside that set raises an illegal flag and forces every data output to zero. This includes the reserved slots, the division-step range and the other units' code space. Register files, forwarding, immediate assembly and pipeline control belong to the surrounding slot.

Top module: `vliw_int_alu`

## Requirements
- R1: While `rst_n` is low, `res_o`, `bres_o`, `cout_o` and `illegal_o` are all 0.
- R2: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge (one cycle of latency).
- R3: Arithmetic wraps modulo 2^32: 0x41 gives src1+src2; 0x52 gives src2-src1 (reversed order); 0x4B, 0x4C, 0x4D and 0x4E give (src1<<n)+src2 for n = 1, 2, 3 and 4.
- R4: Bitwise ops: 0x43 gives a&b, 0x49 gives a|b and 0x57 gives a^b. 0x44 gives ~a&b and 0x4A gives ~a|b, where a=src1 and b=src2.
- R5: Shifts use only src2[4:0] as the amount. 0x4F shifts src1 left, 0x50 shifts it right copying the sign bit, and 0x51 shifts it right filling zeros.
- R6: 0x45 and 0x47 give the signed maximum and minimum of src1 and src2. 0x46 and 0x48 give the unsigned maximum and minimum.
- R7: 0x53 sign-extends src1[7:0] and 0x54 sign-extends src1[15:0]. 0x55 and 0x56 zero-extend the same fields, and 0x58 passes src1 through.
- R8: The compares, each testing src1 against src2 and encoded as code:relation, are 0x59:==, 0x5A:>= signed, 0x5B:>= unsigned, 0x5C:> signed, 0x5D:> unsigned, 0x5E:<= signed, 0x5F:<= unsigned, 0x60:< signed, 0x61:< unsigned and 0x62:!=. A compare drives `bres_o` with the outcome and `res_o` with 1 when true and 0 when false.
- R9: The logical booleans treat a non-zero operand as true: 0x68 is AND, 0x66 is OR, 0x63 is NAND and 0x64 is NOR. Their 0/1 outcome goes to both `bres_o` and `res_o`. Code 0x67 sets `bres_o` to (src1!=0) with `res_o`=0.
- R10: Codes 0x38 to 0x3F return src1 when `bsel_i`=1 and src2 otherwise. Codes 0x30 to 0x37 return src1 when `bsel_i`=0 and src2 otherwise. The low three code bits have no effect.
- R11: Codes 0x78 to 0x7F compute src1+src2+`bsel_i`. The low 32 bits go to `res_o`, and bit 32 goes to both `cout_o` and `bres_o`. Every other code leaves `cout_o` at 0.
- R12: Every code not listed in R3 to R11 sets `illegal_o`=1 and drives `res_o`, `bres_o` and `cout_o` to 0. This covers 0x40, 0x42, 0x65, 0x69 to 0x6F, 0x70 to 0x77, and 0x00 to 0x2F. A listed code sets `illegal_o`=0, and `bres_o` is 0 outside R8, R9 and R11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 7 | Operation code |
| src1_i | input | 32 | First operand |
| src2_i | input | 32 | Second operand (register or immediate) |
| bsel_i | input | 1 | Branch-register input: select condition or carry-in |
| res_o | output | 32 | General result |
| bres_o | output | 1 | Branch-register result |
| cout_o | output | 1 | Carry-out of the carry-chained add |
| illegal_o | output | 1 | Unsupported operation code |

## Verification
The bench builds the unit with its default 32-bit data width, the only width at which the 5-bit shift field and the byte and halfword extensions sit at their real boundaries. At that width, random operands reach sign-boundary differences between signed and unsigned compares, min/max and arithmetic shift. They also reach carry-out from full-range sums and the wrap of shift amounts above 31. Opcodes are drawn both from the whole 7-bit space and from the dense ALU range, so reserved slots that sit between valid codes are hit many times.

// File: rtl/vliw_int_alu_pkg.sv
package vliw_int_alu_pkg;

    localparam int OPC_W = 7;

    typedef enum logic [5:0] {
        K_ILL,
        K_ADD, K_SUB, K_SH1ADD, K_SH2ADD, K_SH3ADD, K_SH4ADD, K_ADDCG,
        K_AND, K_ANDC, K_OR, K_ORC, K_XOR,
        K_SHL, K_SHR, K_SHRU,
        K_MAX, K_MAXU, K_MIN, K_MINU,
        K_SXTB, K_SXTH, K_ZXTB, K_ZXTH, K_MOV,
        K_CEQ, K_CGE, K_CGEU, K_CGT, K_CGTU, K_CLE, K_CLEU, K_CLT, K_CLTU, K_CNE,
        K_LNAND, K_LNOR, K_LOR, K_LAND, K_TOBR,
        K_SEL, K_SELF
    } kind_e;

    function automatic logic is_adder(kind_e k);
        return k inside {K_ADD, K_SUB, K_SH1ADD, K_SH2ADD, K_SH3ADD, K_SH4ADD, K_ADDCG};
    endfunction

    function automatic logic is_flag(kind_e k);
        return k inside {K_CEQ, K_CGE, K_CGEU, K_CGT, K_CGTU, K_CLE, K_CLEU, K_CLT,
                         K_CLTU, K_CNE, K_LNAND, K_LNOR, K_LOR, K_LAND, K_TOBR};
    endfunction

endpackage

// File: rtl/vliw_int_alu_decode.sv
module vliw_int_alu_decode
    import vliw_int_alu_pkg::*;
(
    input  logic [OPC_W-1:0] op_i,
    output kind_e            kind_o
);
    always_comb begin
        kind_o = K_ILL;
        casez (op_i)
            7'b1111???: kind_o = K_ADDCG;
            7'b0111???: kind_o = K_SEL;
            7'b0110???: kind_o = K_SELF;
            7'h41: kind_o = K_ADD;
            7'h43: kind_o = K_AND;
            7'h44: kind_o = K_ANDC;
            7'h45: kind_o = K_MAX;
            7'h46: kind_o = K_MAXU;
            7'h47: kind_o = K_MIN;
            7'h48: kind_o = K_MINU;
            7'h49: kind_o = K_OR;
            7'h4A: kind_o = K_ORC;
            7'h4B: kind_o = K_SH1ADD;
            7'h4C: kind_o = K_SH2ADD;
            7'h4D: kind_o = K_SH3ADD;
            7'h4E: kind_o = K_SH4ADD;
            7'h4F: kind_o = K_SHL;
            7'h50: kind_o = K_SHR;
            7'h51: kind_o = K_SHRU;
            7'h52: kind_o = K_SUB;
            7'h53: kind_o = K_SXTB;
            7'h54: kind_o = K_SXTH;
            7'h55: kind_o = K_ZXTB;
            7'h56: kind_o = K_ZXTH;
            7'h57: kind_o = K_XOR;
            7'h58: kind_o = K_MOV;
            7'h59: kind_o = K_CEQ;
            7'h5A: kind_o = K_CGE;
            7'h5B: kind_o = K_CGEU;
            7'h5C: kind_o = K_CGT;
            7'h5D: kind_o = K_CGTU;
            7'h5E: kind_o = K_CLE;
            7'h5F: kind_o = K_CLEU;
            7'h60: kind_o = K_CLT;
            7'h61: kind_o = K_CLTU;
            7'h62: kind_o = K_CNE;
            7'h63: kind_o = K_LNAND;
            7'h64: kind_o = K_LNOR;
            7'h66: kind_o = K_LOR;
            7'h67: kind_o = K_TOBR;
            7'h68: kind_o = K_LAND;
            default: kind_o = K_ILL;
        endcase
    end
endmodule

// File: rtl/vliw_int_alu_adder.sv
module vliw_int_alu_adder
    import vliw_int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  kind_e          kind_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           cin_i,
    output logic [W-1:0]   sum_o,
    output logic           carry_o
);
    logic [W:0] x, y, tot;
    logic       c;

    always_comb begin
        x = {1'b0, a_i};
        y = {1'b0, b_i};
        c = 1'b0;
        case (kind_i)
            K_SUB:    begin x = {1'b0, ~a_i}; c = 1'b1; end
            K_SH1ADD: x = {1'b0, a_i << 1};
            K_SH2ADD: x = {1'b0, a_i << 2};
            K_SH3ADD: x = {1'b0, a_i << 3};
            K_SH4ADD: x = {1'b0, a_i << 4};
            K_ADDCG:  c = cin_i;
            default:  ;
        endcase
        tot     = x + y + {{W{1'b0}}, c};
        sum_o   = tot[W-1:0];
        carry_o = tot[W];
    end
endmodule

// File: rtl/vliw_int_alu_flag.sv
module vliw_int_alu_flag
    import vliw_int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  kind_e        kind_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         lts_o,
    output logic         ltu_o,
    output logic         flag_o
);
    logic eq, an, bn;

    always_comb begin
        eq    = (a_i == b_i);
        lts_o = ($signed(a_i) < $signed(b_i));
        ltu_o = (a_i < b_i);
        an    = |a_i;
        bn    = |b_i;
        case (kind_i)
            K_CEQ:   flag_o = eq;
            K_CNE:   flag_o = !eq;
            K_CGE:   flag_o = !lts_o;
            K_CGEU:  flag_o = !ltu_o;
            K_CGT:   flag_o = !lts_o && !eq;
            K_CGTU:  flag_o = !ltu_o && !eq;
            K_CLE:   flag_o = lts_o || eq;
            K_CLEU:  flag_o = ltu_o || eq;
            K_CLT:   flag_o = lts_o;
            K_CLTU:  flag_o = ltu_o;
            K_LAND:  flag_o = an && bn;
            K_LOR:   flag_o = an || bn;
            K_LNAND: flag_o = !(an && bn);
            K_LNOR:  flag_o = !(an || bn);
            K_TOBR:  flag_o = an;
            default: flag_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/vliw_int_alu_bits.sv
module vliw_int_alu_bits
    import vliw_int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  kind_e        kind_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         bsel_i,
    input  logic         lts_i,
    input  logic         ltu_i,
    output logic [W-1:0] res_o
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh;

    always_comb begin
        sh = b_i[SHW-1:0];
        case (kind_i)
            K_AND:   res_o = a_i & b_i;
            K_ANDC:  res_o = ~a_i & b_i;
            K_OR:    res_o = a_i | b_i;
            K_ORC:   res_o = ~a_i | b_i;
            K_XOR:   res_o = a_i ^ b_i;
            K_SHL:   res_o = a_i << sh;
            K_SHR:   res_o = $unsigned($signed(a_i) >>> sh);
            K_SHRU:  res_o = a_i >> sh;
            K_MAX:   res_o = lts_i ? b_i : a_i;
            K_MIN:   res_o = lts_i ? a_i : b_i;
            K_MAXU:  res_o = ltu_i ? b_i : a_i;
            K_MINU:  res_o = ltu_i ? a_i : b_i;
            K_SXTB:  res_o = {{(W-8){a_i[7]}}, a_i[7:0]};
            K_SXTH:  res_o = {{(W-16){a_i[15]}}, a_i[15:0]};
            K_ZXTB:  res_o = {{(W-8){1'b0}}, a_i[7:0]};
            K_ZXTH:  res_o = {{(W-16){1'b0}}, a_i[15:0]};
            K_MOV:   res_o = a_i;
            K_SEL:   res_o = bsel_i ? a_i : b_i;
            K_SELF:  res_o = bsel_i ? b_i : a_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/vliw_int_alu.sv
module vliw_int_alu
    import vliw_int_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  op_i,
    input  logic [DATA_W-1:0] src1_i,
    input  logic [DATA_W-1:0] src2_i,
    input  logic              bsel_i,
    output logic [DATA_W-1:0] res_o,
    output logic              bres_o,
    output logic              cout_o,
    output logic              illegal_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              bres;
        logic              cout;
        logic              ill;
    } out_t;

    kind_e             kind;
    logic [DATA_W-1:0] sum, bits_res;
    logic              carry, lts, ltu, flag;
    out_t              out_d, out_q;

    vliw_int_alu_decode u_dec (.op_i(op_i), .kind_o(kind));

    vliw_int_alu_adder #(.W(DATA_W)) u_add (
        .kind_i(kind), .a_i(src1_i), .b_i(src2_i), .cin_i(bsel_i),
        .sum_o(sum), .carry_o(carry)
    );

    vliw_int_alu_flag #(.W(DATA_W)) u_flag (
        .kind_i(kind), .a_i(src1_i), .b_i(src2_i),
        .lts_o(lts), .ltu_o(ltu), .flag_o(flag)
    );

    vliw_int_alu_bits #(.W(DATA_W)) u_bits (
        .kind_i(kind), .a_i(src1_i), .b_i(src2_i), .bsel_i(bsel_i),
        .lts_i(lts), .ltu_i(ltu), .res_o(bits_res)
    );

    always_comb begin
        out_d = '0;
        if (kind == K_ILL) begin
            out_d.ill = 1'b1;
        end else if (is_adder(kind)) begin
            out_d.res = sum;
            if (kind == K_ADDCG) begin
                out_d.bres = carry;
                out_d.cout = carry;
            end
        end else if (is_flag(kind)) begin
            out_d.bres = flag;
            if (kind != K_TOBR) out_d.res = {{(DATA_W-1){1'b0}}, flag};
        end else begin
            out_d.res = bits_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o     = out_q.res;
    assign bres_o    = out_q.bres;
    assign cout_o    = out_q.cout;
    assign illegal_o = out_q.ill;
endmodule

// File: rtl/vliw_int_alu_chk.sv
module vliw_int_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [6:0]   op_i,
    input logic [W-1:0] src1_i,
    input logic [W-1:0] src2_i,
    input logic         bsel_i,
    input logic [W-1:0] res_o,
    input logic         bres_o,
    input logic         cout_o,
    input logic         illegal_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R12
    a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (res_o == '0) && !bres_o && !cout_o);

    // R11
    a_r11_cout_only_carry_add: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i[6:3]) != 4'b1111) |-> !cout_o);

    // R10
    a_r10_select: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i[6:4]) == 3'b011) |->
        res_o == (($past(bsel_i) == $past(op_i[3])) ? $past(src1_i) : $past(src2_i)));

    // R8
    a_r8_compare_zero_one: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) >= 7'h59 && $past(op_i) <= 7'h62) |->
        res_o == {{(W-1){1'b0}}, bres_o});

    // R9
    a_r9_to_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 7'h67) |-> (bres_o == ($past(src1_i) != '0)) && res_o == '0);

    // R3
    a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 7'h41) |-> res_o == $past(src1_i) + $past(src2_i));
endmodule

bind vliw_int_alu vliw_int_alu_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .src1_i(src1_i), .src2_i(src2_i),
    .bsel_i(bsel_i), .res_o(res_o), .bres_o(bres_o), .cout_o(cout_o),
    .illegal_o(illegal_o)
);

// File: tb/vliw_int_alu_bench.sv
module vliw_int_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  op = '0;
    logic [31:0] s1 = '0, s2 = '0;
    logic        bin = 1'b0;
    logic [31:0] res;
    logic        bres, cout, ill;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    vliw_int_alu u_vliw_int_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op), .src1_i(s1), .src2_i(s2), .bsel_i(bin),
        .res_o(res), .bres_o(bres), .cout_o(cout), .illegal_o(ill)
    );

    // expected {ill, cout, bres, res}
    function automatic logic [34:0] model(logic [6:0] o, logic [31:0] a, logic [31:0] b, logic c);
        logic [32:0] w;
        logic f;
        logic [4:0] sh;
        sh = b[4:0];
        if (o[6:3] == 4'b1111) begin
            w = {1'b0, a} + {1'b0, b} + {32'd0, c};
            return {1'b0, w[32], w[32], w[31:0]};
        end
        if (o[6:3] == 4'b0111) return {3'b000, c ? a : b};
        if (o[6:3] == 4'b0110) return {3'b000, c ? b : a};
        case (o)
            7'h41: return {3'b000, a + b};
            7'h52: return {3'b000, b - a};
            7'h4B: return {3'b000, (a << 1) + b};
            7'h4C: return {3'b000, (a << 2) + b};
            7'h4D: return {3'b000, (a << 3) + b};
            7'h4E: return {3'b000, (a << 4) + b};
            7'h43: return {3'b000, a & b};
            7'h44: return {3'b000, ~a & b};
            7'h49: return {3'b000, a | b};
            7'h4A: return {3'b000, ~a | b};
            7'h57: return {3'b000, a ^ b};
            7'h4F: return {3'b000, a << sh};
            7'h50: return {3'b000, 32'($signed(a) >>> sh)};
            7'h51: return {3'b000, a >> sh};
            7'h45: return {3'b000, ($signed(a) > $signed(b)) ? a : b};
            7'h47: return {3'b000, ($signed(a) < $signed(b)) ? a : b};
            7'h46: return {3'b000, (a > b) ? a : b};
            7'h48: return {3'b000, (a < b) ? a : b};
            7'h53: return {3'b000, 32'($signed(a[7:0]))};
            7'h54: return {3'b000, 32'($signed(a[15:0]))};
            7'h55: return {3'b000, 24'd0, a[7:0]};
            7'h56: return {3'b000, 16'd0, a[15:0]};
            7'h58: return {3'b000, a};
            7'h67: return {2'b00, a != 0, 32'd0};
            default: ;
        endcase
        case (o)
            7'h59: f = (a == b);
            7'h5A: f = ($signed(a) >= $signed(b));
            7'h5B: f = (a >= b);
            7'h5C: f = ($signed(a) > $signed(b));
            7'h5D: f = (a > b);
            7'h5E: f = ($signed(a) <= $signed(b));
            7'h5F: f = (a <= b);
            7'h60: f = ($signed(a) < $signed(b));
            7'h61: f = (a < b);
            7'h62: f = (a != b);
            7'h63: f = !((a != 0) && (b != 0));
            7'h64: f = !((a != 0) || (b != 0));
            7'h66: f = (a != 0) || (b != 0);
            7'h68: f = (a != 0) && (b != 0);
            default: return {1'b1, 34'd0};
        endcase
        return {2'b00, f, 31'd0, f};
    endfunction

    function automatic string tag(logic [6:0] o);
        if (o[6:3] == 4'b1111) return "R11";
        if (o[6:4] == 3'b011) return "R10";
        if (o inside {7'h41, 7'h52, [7'h4B:7'h4E]}) return "R3";
        if (o inside {7'h43, 7'h44, 7'h49, 7'h4A, 7'h57}) return "R4";
        if (o inside {[7'h4F:7'h51]}) return "R5";
        if (o inside {[7'h45:7'h48]}) return "R6";
        if (o inside {[7'h53:7'h56], 7'h58}) return "R7";
        if (o inside {[7'h59:7'h62]}) return "R8";
        if (o inside {7'h63, 7'h64, 7'h66, 7'h67, 7'h68}) return "R9";
        return "R12";
    endfunction

    task automatic compare(string req, logic [34:0] exp);
        n_chk++;
        if ({ill, cout, bres, res} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h: got ill=%b cout=%b bres=%b res=%h, expected ill=%b cout=%b bres=%b res=%h",
                     req, op, ill, cout, bres, res, exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic run(logic [6:0] o, logic [31:0] a, logic [31:0] b, logic c);
        @(negedge clk);
        op = o; s1 = a; s2 = b; bin = c;
        @(negedge clk);
        compare(tag(o), model(o, a, b, c));
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'd0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000 | $urandom_range(0, 3);
            3: return $urandom_range(0, 40);
            default: return $urandom();
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357_9BDF));
        op = 7'h41; s1 = 32'h1234; s2 = 32'h1; bin = 1'b1;
        @(posedge clk); @(negedge clk);
        compare("R1", 35'd0);                           // R1 reset state
        rst_n = 1'b1;

        // R2: output holds until the next rising edge
        run(7'h41, 32'd10, 32'd20, 1'b0);
        @(negedge clk);
        op = 7'h52; s1 = 32'd3; s2 = 32'd100;
        #2 compare("R2", {3'b000, 32'd30});
        @(negedge clk);
        compare("R2", {3'b000, 32'd97});

        run(7'h41, 32'hFFFF_FFFF, 32'd2, 1'b0);         // R3 wrap
        run(7'h52, 32'd7, 32'd5, 1'b0);                 // R3 reversed subtract
        run(7'h4E, 32'h1000_0001, 32'd3, 1'b0);         // R3 shift-4 add
        run(7'h44, 32'h0F0F_0F0F, 32'hFFFF_0000, 1'b0); // R4
        run(7'h4A, 32'hFFFF_FFFF, 32'd0, 1'b0);         // R4
        run(7'h50, 32'h8000_0000, 32'd31, 1'b0);        // R5 sign fill
        run(7'h4F, 32'd1, 32'd33, 1'b0);                // R5 amount wraps
        run(7'h51, 32'h8000_0000, 32'hFFFF_FFE4, 1'b0); // R5
        run(7'h45, 32'hFFFF_FFFF, 32'd1, 1'b0);         // R6 signed max
        run(7'h46, 32'hFFFF_FFFF, 32'd1, 1'b0);         // R6 unsigned max
        run(7'h47, 32'h8000_0000, 32'd0, 1'b0);         // R6
        run(7'h53, 32'h1234_5680, 32'd0, 1'b0);         // R7
        run(7'h56, 32'hABCD_8001, 32'd0, 1'b0);         // R7
        run(7'h60, 32'hFFFF_FFFF, 32'd0, 1'b0);         // R8 signed lt
        run(7'h61, 32'hFFFF_FFFF, 32'd0, 1'b0);         // R8 unsigned lt
        run(7'h5E, 32'd5, 32'd5, 1'b0);                 // R8 le equal
        run(7'h63, 32'd4, 32'd0, 1'b0);                 // R9
        run(7'h67, 32'h0000_0100, 32'd0, 1'b0);         // R9 to branch
        run(7'h68, 32'd0, 32'd9, 1'b0);                 // R9
        run(7'h3D, 32'hAAAA, 32'h5555, 1'b1);           // R10 low bits ignored
        run(7'h38, 32'hAAAA, 32'h5555, 1'b0);           // R10
        run(7'h32, 32'hAAAA, 32'h5555, 1'b0);           // R10 false-select
        run(7'h7B, 32'hFFFF_FFFF, 32'd0, 1'b1);         // R11 carry chain
        run(7'h78, 32'h7FFF_FFFF, 32'd1, 1'b0);         // R11
        run(7'h65, 32'd1, 32'd1, 1'b1);                 // R12 reserved
        run(7'h40, 32'd1, 32'd1, 1'b1);                 // R12
        run(7'h74, 32'd1, 32'd1, 1'b1);                 // R12 division-step range
        run(7'h00, 32'd1, 32'd1, 1'b1);                 // R12 other unit space

        for (int i = 0; i < 3000; i++) begin
            logic [6:0] o;
            if ($urandom_range(0, 2) == 0) o = 7'($urandom_range(0, 127));
            else                           o = 7'($urandom_range(7'h40, 7'h68));
            run(o, pick(), pick(), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule